// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a processor's load/store port and a memory bus that carries one request at a time. It is a blocking, direct-mapped cache with a write-through, no-write-allocate policy. Cached loads that hit return data in the cycle they are presented. A cached load that misses stalls the processor while a whole line is fetched. An uncached load stalls while a single word is fetched. Stores always go to an external write buffer, and they also modify the cached copy when the line is resident. A line-invalidate command drops the addressed line.

The processor holds its request until `stall` is low, and the operation completes at that rising edge. `stall` and `rsp_rdata` are combinational functions of the request and the cache state. Before any read is placed on the bus, the cache waits until the write buffer reports empty. This keeps a load from overtaking older stores.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, `stall` is low while no request is present, and neither `mem_req_valid` nor `wb_push` is asserted.
- R2: A cached read (`req_op`=0, `req_uncached`=0) whose line is valid with a matching tag completes with `stall` low in the same cycle, and `rsp_rdata` equals the latest stored value of that word. No bus request is issued.
- R3: A cached read miss holds `stall` high. It issues one request at the line-aligned address with `mem_req_len`=WORDS, stores the returned beats in word order, and marks the line valid. The held request then hits. The address splits into byte offset [1:0], word [OFF_W-1:2], index [OFF_W+IDX_W-1:OFF_W] and tag in the upper bits.
- R4: An uncached read (`req_op`=0, `req_uncached`=1) holds `stall` high and issues one request at the exact address with `mem_req_len`=1. It returns that word in the cycle after the beat, with `stall` low, and never allocates a line.
- R5: A write (`req_op`=1) with `wb_full` low raises `wb_push` in the same cycle with `wb_addr`, `wb_wdata` and `wb_be` equal to the request, and does not stall. With `wb_full` high it stalls and does not push.
- R6: A cached write that hits modifies only the bytes of the cached word whose `req_be` bit is set (bit b covers data bits 8b+7..8b). A write that misses leaves the cache untouched, so a later read of that line still misses.
- R7: An invalidate (`req_op`=2) completes in one cycle without stalling or pushing, and clears the valid bit of the indexed line, so the next cached read of it misses. `req_op`=3 is a no-op that completes at once.
- R8: `mem_req_valid` is never asserted while `wb_empty` is low.
- R9: At most one bus request is in flight. `mem_req_valid` holds its address and length until `mem_req_ready`, and stays low while response beats are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 read, 1 write, 2 invalidate line, 3 no-op |
| req_uncached | input | 1 | Address lies in an uncached region |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_rdata | output | 32 | Load data (combinational) |
| stall | output | 1 | Request not completed this cycle (combinational) |
| wb_push | output | 1 | Store entry written to the write buffer |
| wb_addr | output | ADDR_W | Store address |
| wb_wdata | output | 32 | Store data |
| wb_be | output | 4 | Store byte enables |
| wb_full | input | 1 | Write buffer cannot accept an entry |
| wb_empty | input | 1 | Write buffer has no pending entry |
| mem_req_valid | output | 1 | Read request to the bus |
| mem_req_ready | input | 1 | Bus accepts the request |
| mem_req_addr | output | ADDR_W | Read start address |
| mem_req_len | output | LEN_W | Number of words requested |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench keeps its own record of line tags, a shadow of memory updated in store order, and a model write buffer with controllable drain. It predicts, in the first cycle of every request, whether the request must stall.

Several errors are targeted directly:
- Allocating on a write miss or on an uncached read makes a later predicted miss hit, or a predicted hit miss.
- Forgetting the byte enables on a write hit returns whole-word data from the next hit.
- Issuing a read before the buffer drains returns stale memory contents. The bench's responder also flags it the moment the request appears.
- A wrong burst length or unaligned line address is caught at the request.
- Pushing into a full buffer is caught when the write first stalls.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_INVAL = 2'd2,
    OP_NONE  = 2'd3
  } dc_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRAIN,
    S_REQ,
    S_FILL,
    S_UDONE
  } dc_state_e;

  // Byte-lane merge of a store into an existing word.
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/dcache_store.sv
module dcache_store #(
  parameter int LINES = 64,
  parameter int WORDS = 8,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(LINES),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [WRD_W-1:0] rd_wrd,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WRD_W-1:0] wr_wrd,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  import dcache_pkg::*;

  localparam int ENTRIES = LINES * WORDS;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [31:0]      dat_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (set_en) valid_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
    if (wr_en)  dat_q[{wr_idx, wr_wrd}] <= merge_bytes(dat_q[{wr_idx, wr_wrd}], wr_data, wr_be);
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[{rd_idx, rd_wrd}];

endmodule

// File: rtl/dcache_fsm.sv
module dcache_fsm #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8,
  localparam int WRD_W = $clog2(WORDS),
  localparam int OFF_W = WRD_W + 2,
  localparam int LEN_W = $clog2(WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_fill,
  input  logic                    go_unc,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    wb_empty,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LEN_W-1:0]        mem_req_len,
  input  logic                    mem_rsp_valid,
  input  logic [31:0]             mem_rsp_data,
  output logic                    in_idle,
  output logic                    in_udone,
  output logic                    fill_beat,
  output logic                    fill_we,
  output logic [WRD_W-1:0]        fill_wrd,
  output logic                    fill_done,
  output logic [ADDR_W-OFF_W-1:0] line_hi,
  output logic [31:0]             ubuf
);
  import dcache_pkg::*;

  dc_state_e          st_q;
  logic               unc_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WRD_W-1:0]   cnt_q;
  logic [31:0]        ubuf_q;

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      unc_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (go_fill || go_unc) begin
          st_q   <= S_DRAIN;
          unc_q  <= go_unc;
          addr_q <= req_addr;
        end
        S_DRAIN: if (wb_empty) st_q <= S_REQ;
        S_REQ: if (mem_req_ready) begin
          st_q  <= S_FILL;
          cnt_q <= '0;
        end
        S_FILL: if (mem_rsp_valid) begin
          if (unc_q) begin
            st_q <= S_UDONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == WRD_W'(WORDS - 1)) st_q <= S_IDLE;
          end
        end
        S_UDONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_rsp_valid && unc_q) ubuf_q <= mem_rsp_data;
  end

  assign in_idle       = (st_q == S_IDLE);
  assign in_udone      = (st_q == S_UDONE);
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = unc_q ? addr_q : line_base(addr_q);
  assign mem_req_len   = unc_q ? LEN_W'(1) : LEN_W'(WORDS);
  assign fill_beat     = (st_q == S_FILL) && mem_rsp_valid;
  assign fill_we       = fill_beat && !unc_q;
  assign fill_wrd      = cnt_q;
  assign fill_done     = fill_we && (cnt_q == WRD_W'(WORDS - 1));
  assign line_hi       = addr_q[ADDR_W-1:OFF_W];
  assign ubuf          = ubuf_q;

endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 8,
  localparam int LEN_W = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_uncached,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic [31:0]       rsp_rdata,
  output logic              stall,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [31:0]       wb_wdata,
  output logic [3:0]        wb_be,
  input  logic              wb_full,
  input  logic              wb_empty,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  import dcache_pkg::*;

  localparam int WRD_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = WRD_W + 2;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WRD_W-1:0] f_wrd(input logic [ADDR_W-1:0] a);
    return a[2 +: WRD_W];
  endfunction

  dc_op_e op;
  assign op = dc_op_e'(req_op);

  // array side
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [31:0]      rd_data;
  logic             arr_we;
  logic [IDX_W-1:0] arr_widx;
  logic [WRD_W-1:0] arr_wwrd;
  logic [31:0]      arr_wdata;
  logic [3:0]       arr_wbe;

  // sequencer side
  logic                    in_idle, in_udone;
  logic                    fill_beat, fill_we, fill_done;
  logic [WRD_W-1:0]        fill_wrd;
  logic [ADDR_W-OFF_W-1:0] line_hi;
  logic [31:0]             ubuf;

  // named internal events
  logic tag_match, ev_rd_hit, ev_wr_hit, ev_inv, go_fill, go_unc, is_read, accept;

  assign tag_match = rd_valid && (rd_tag == f_tag(req_addr));
  assign is_read   = in_idle && req_valid && (op == OP_READ);
  assign ev_rd_hit = is_read && !req_uncached && tag_match;
  assign go_fill   = is_read && !req_uncached && !tag_match;
  assign go_unc    = is_read && req_uncached;
  assign wb_push   = in_idle && req_valid && (op == OP_WRITE) && !wb_full;
  assign ev_wr_hit = wb_push && !req_uncached && tag_match;
  assign ev_inv    = in_idle && req_valid && (op == OP_INVAL);

  assign accept = in_udone ||
                  (in_idle && (ev_rd_hit || wb_push || ev_inv || (op == OP_NONE)));
  assign stall  = req_valid && !accept;

  assign rsp_rdata = in_udone ? ubuf : rd_data;
  assign wb_addr   = req_addr;
  assign wb_wdata  = req_wdata;
  assign wb_be     = req_be;

  assign arr_we    = ev_wr_hit || fill_we;
  assign arr_widx  = fill_we ? line_hi[IDX_W-1:0] : f_idx(req_addr);
  assign arr_wwrd  = fill_we ? fill_wrd : f_wrd(req_addr);
  assign arr_wdata = fill_we ? mem_rsp_data : req_wdata;
  assign arr_wbe   = fill_we ? 4'hF : req_be;

  dcache_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_idx(req_addr)),
    .rd_wrd   (f_wrd(req_addr)),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (arr_we),
    .wr_idx   (arr_widx),
    .wr_wrd   (arr_wwrd),
    .wr_data  (arr_wdata),
    .wr_be    (arr_wbe),
    .set_en   (fill_done),
    .set_idx  (line_hi[IDX_W-1:0]),
    .set_tag  (line_hi[ADDR_W-OFF_W-1:IDX_W]),
    .clr_en   (ev_inv),
    .clr_idx  (f_idx(req_addr))
  );

  dcache_fsm #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_fill       (go_fill),
    .go_unc        (go_unc),
    .req_addr      (req_addr),
    .wb_empty      (wb_empty),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_len   (mem_req_len),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .in_idle       (in_idle),
    .in_udone      (in_udone),
    .fill_beat     (fill_beat),
    .fill_we       (fill_we),
    .fill_wrd      (fill_wrd),
    .fill_done     (fill_done),
    .line_hi       (line_hi),
    .ubuf          (ubuf)
  );

endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 8,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              stall,
  input logic              wb_push,
  input logic              wb_full,
  input logic              wb_empty,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LEN_W-1:0]  mem_req_len,
  input logic              fill_beat,
  input logic              fill_done,
  input logic              ev_inv
);
  localparam int OFF_W = $clog2(WORDS) + 2;

  AST_REQ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> wb_empty); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)); // R9
  AST_NO_REQ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat |-> !mem_req_valid); // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> !wb_full); // R5
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && req_valid |-> stall); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len == LEN_W'(WORDS)) || (mem_req_len == LEN_W'(1))); // R4
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_req_len == LEN_W'(WORDS)) |-> (mem_req_addr[OFF_W-1:0] == '0)); // R3
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !req_valid || !stall); // R3
  AST_INV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv |-> !wb_push && !stall); // R7

endmodule

bind dcache_wt dcache_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LEN_W(LEN_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .stall         (stall),
  .wb_push       (wb_push),
  .wb_full       (wb_full),
  .wb_empty      (wb_empty),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_len   (mem_req_len),
  .fill_beat     (fill_beat),
  .fill_done     (fill_done),
  .ev_inv        (ev_inv)
);

// File: tb/test_dcache_wt.sv
module test_dcache_wt;
  localparam int LINES = 8;
  localparam int WORDS = 4;
  localparam int WB_DEPTH = 4;
  localparam int LEN_W = $clog2(WORDS + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd3;
  logic        req_uncached = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] rsp_rdata;
  logic        stall, wb_push;
  logic [31:0] wb_addr, wb_wdata;
  logic [3:0]  wb_be;
  logic        wb_full = 1'b0, wb_empty = 1'b1;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [LEN_W-1:0] mem_req_len;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  dcache_wt #(.ADDR_W(32), .LINES(LINES), .WORDS(WORDS)) i_dcache_wt (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] shadow [512];
  logic [31:0] phys   [512];
  bit          bvalid [LINES];
  logic [31:0] btag   [LINES];
  logic [31:0] wq_a[$], wq_d[$];
  logic [3:0]  wq_b[$];
  bit          drain_en = 1;
  bit          pend_push = 0;
  logic [31:0] pend_a, pend_d;
  logic [3:0]  pend_b;
  logic [31:0] cur_addr = '0;
  bit          cur_unc = 0;
  logic [31:0] last_rd;
  bit          last_first_stall;

  function automatic int widx(input logic [31:0] a);
    return int'((a >> 2) & 32'd511);
  endfunction
  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] m = 0;
    for (int b = 0; b < 4; b++) if (be[b]) m = m | (32'hFF << (8 * b));
    return (o & ~m) | (n & m);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // write buffer model
  always @(posedge clk) begin
    if (rst_n) begin
      if (wq_a.size() > 0 && drain_en && ($urandom % 3 == 0)) begin
        phys[widx(wq_a[0])] = bmerge(phys[widx(wq_a[0])], wq_d[0], wq_b[0]);
        void'(wq_a.pop_front()); void'(wq_d.pop_front()); void'(wq_b.pop_front());
      end
      if (pend_push) begin
        wq_a.push_back(pend_a); wq_d.push_back(pend_d); wq_b.push_back(pend_b);
      end
      wb_full  <= (wq_a.size() == WB_DEPTH);
      wb_empty <= (wq_a.size() == 0);
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mem_req_valid) begin
        logic [31:0] base;
        int len;
        base = mem_req_addr;
        len = int'(mem_req_len);
        chk(wq_a.size() == 0, "R8 request with buffer not drained", wq_a.size(), 0);
        if (cur_unc) begin
          chk(base == cur_addr && len == 1, "R4 single-word request", base, cur_addr);
        end else begin
          chk(base == (cur_addr & ~32'hF) && len == WORDS, "R3 line request", base, cur_addr & ~32'hF);
        end
        repeat ($urandom % 3) @(negedge clk);
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        for (int i = 0; i < len; i++) begin
          repeat ($urandom % 3) @(negedge clk);
          #1;
          chk(!mem_req_valid, "R9 second request in flight", mem_req_valid, 0);
          mem_rsp_valid = 1;
          mem_rsp_data = phys[widx(base + 32'(4 * i))];
          @(negedge clk);
          mem_rsp_valid = 0;
        end
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data,
                       input logic [3:0] be, input bit unc);
    int idx;
    logic [31:0] tg;
    bit exp_hit, exp_st;
    int waitc;
    string rq;
    idx = int'((addr >> 4) % LINES);
    tg = addr >> 7;
    waitc = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_wdata = data; req_be = be; req_uncached = unc;
    cur_addr = addr; cur_unc = unc;
    #2;
    exp_hit = !unc && bvalid[idx] && btag[idx] == tg;
    case (op)
      2'd0: begin exp_st = !exp_hit; rq = unc ? "R4" : (exp_hit ? "R2" : "R3"); end
      2'd1: begin exp_st = (wq_a.size() == WB_DEPTH); rq = "R5"; end
      default: begin exp_st = 0; rq = "R7"; end
    endcase
    last_first_stall = stall;
    chk(stall == exp_st, {rq, " first-cycle stall"}, stall, exp_st);
    if (op == 2'd1 && exp_st) chk(!wb_push, "R5 push while full", wb_push, 0);
    while (stall && waitc < 1000) begin
      @(negedge clk); #2; waitc++;
    end
    if (stall) chk(0, {rq, " request never completed"}, stall, 0);
    case (op)
      2'd0: begin
        last_rd = rsp_rdata;
        chk(rsp_rdata == shadow[widx(addr)], {rq, " read data"}, rsp_rdata, shadow[widx(addr)]);
        if (!unc) begin bvalid[idx] = 1; btag[idx] = tg; end
      end
      2'd1: begin
        chk(wb_push && wb_addr == addr && wb_wdata == data && wb_be == be, "R5 buffer push", wb_wdata, data);
        pend_push = 1; pend_a = addr; pend_d = data; pend_b = be;
        shadow[widx(addr)] = bmerge(shadow[widx(addr)], data, be);
      end
      2'd2: begin
        chk(!wb_push, "R7 invalidate pushed", wb_push, 0);
        bvalid[idx] = 0;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    pend_push = 0;
    req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R9 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) begin
      phys[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      shadow[i] = phys[i];
    end
    for (int i = 0; i < LINES; i++) begin bvalid[i] = 0; btag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk(!stall, "R1 stall after reset", stall, 0);
    chk(!mem_req_valid, "R1 bus idle after reset", mem_req_valid, 0);
    chk(!wb_push, "R1 no push after reset", wb_push, 0);

    // miss then hit
    do_op(2'd0, 32'h40, 0, 0, 0);
    chk(last_first_stall, "R1 line invalid after reset", last_first_stall, 1);
    do_op(2'd0, 32'h44, 0, 0, 0);
    chk(!last_first_stall, "R2 hit after refill", last_first_stall, 0);

    // byte-enable write hit
    do_op(2'd1, 32'h44, 32'hAABBCCDD, 4'b0101, 0);
    do_op(2'd0, 32'h44, 0, 0, 0);
    chk(!last_first_stall && last_rd == shadow[widx(32'h44)], "R6 merged bytes on hit", last_rd, shadow[widx(32'h44)]);

    // write miss does not allocate
    do_op(2'd2, 32'h1C0, 0, 0, 0);
    do_op(2'd1, 32'h1C0, 32'h12345678, 4'hF, 0);
    do_op(2'd0, 32'h1C0, 0, 0, 0);
    chk(last_first_stall, "R6 write miss allocated", last_first_stall, 1);

    // invalidate
    do_op(2'd0, 32'h80, 0, 0, 0);
    do_op(2'd2, 32'h84, 0, 0, 0);
    do_op(2'd0, 32'h80, 0, 0, 0);
    chk(last_first_stall, "R7 invalidated line hit", last_first_stall, 1);
    do_op(2'd3, 32'h0, 0, 0, 0);

    // uncached reads never allocate
    do_op(2'd0, 32'h404, 0, 0, 1);
    do_op(2'd0, 32'h404, 0, 0, 1);
    chk(last_first_stall, "R4 uncached read stall", last_first_stall, 1);

    // full buffer
    drain_en = 0;
    for (int i = 0; i < WB_DEPTH; i++) do_op(2'd1, 32'h100 + 32'(4 * i), 32'h1000 + 32'(i), 4'hF, 0);
    fork begin repeat (6) @(posedge clk); drain_en = 1; end join_none
    do_op(2'd1, 32'h110, 32'hFEEDF00D, 4'hF, 0);
    chk(last_first_stall, "R5 stall when full", last_first_stall, 1);

    // read must wait for older writes
    drain_en = 0;
    do_op(2'd1, 32'h208, 32'hCAFEBABE, 4'hF, 0);
    fork begin repeat (8) @(posedge clk); drain_en = 1; end join_none
    do_op(2'd0, 32'h208, 0, 0, 0);
    chk(last_rd == 32'hCAFEBABE, "R8 read overtook write", last_rd, 32'hCAFEBABE);

    // random mix
    for (int n = 0; n < 700; n++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 100);
      a = (n % 5 == 0) ? (($urandom % 256) * 4) : (($urandom % 64) * 4);
      if (r < 40)      do_op(2'd0, a, 0, 0, 0);
      else if (r < 52) do_op(2'd0, 32'h400 + ($urandom % 64) * 4, 0, 0, 1);
      else if (r < 80) do_op(2'd1, a, $urandom, 4'($urandom), 0);
      else if (r < 88) do_op(2'd1, 32'h400 + ($urandom % 64) * 4, $urandom, 4'($urandom), 1);
      else if (r < 96) do_op(2'd2, a, 0, 0, 0);
      else             do_op(2'd3, a, 0, 0, 0);
    end

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule